// File: doc/BRIEF.md
# Link-Up Monitor with Recovery Pulse

This block sits beside a serial-link controller and watches two of its 32-bit debug status words. From the second word it decides, on every cycle, whether the link can be used: the up flag must be set and the training flag must be clear. That decision is registered and driven out as `link_up_o`.

After a `start_i` pulse, the block waits for the link to come up. Each waiting cycle counts against a polling budget. If the budget runs out, a sticky timeout error is raised. Once the link is up, the block waits a settle interval. It then looks at the 6-bit training-state code in the first debug word and at the receiver-valid flag. If the code shows the receiver-lock recovery state while the receiver is not valid, a speed change has stalled.

The cure for a stall is a two-step request to the PHY register port. A one-cycle request asks the port to turn on the two receiver override enables. A hold interval follows. A second one-cycle request then asks the port to turn them off again. The read-modify-write of the override register (bit 5 receive-data enable, bit 3 receive-PLL enable) is done by the port. This block only says when each step happens.

Top module: `link_up_monitor`

## Requirements
- R1: `link_up_o` is 1 in the cycle after `dbg1_i[4]`=1 and `dbg1_i[29]`=0 are sampled, and 0 in the cycle after any other value. This holds whatever the sequencer is doing.
- R2: The training-state code is `dbg0_i[5:0]`. Bits 31:6 of `dbg0_i` have no effect on the stall decision.
- R3: A stall is declared at the end of the settle interval when the code equals `RCV_LOCK_CODE` (default 6'h0D) and `rx_valid_i`=0. Counting the clock edge that samples `start_i` as edge 1, with the link already up, `ovr_set_o` is a one-cycle pulse after edge `SETTLE_CYC`+2.
- R4: When the stall condition is false at the end of the settle interval, neither `ovr_set_o` nor `ovr_clr_o` pulses, and the sequencer returns to idle.
- R5: `ovr_clr_o` is a one-cycle pulse exactly `PULSE_CYC`+1 cycles after `ovr_set_o`. Each stall gives one set pulse and one clear pulse, and the two never overlap.
- R6: `stall_o` rises in the same cycle as `ovr_set_o` and stays at 1 until the next `start_i`.
- R7: If the link is not up after `POLL_BUDGET` polling cycles, `timeout_o` rises after edge `POLL_BUDGET`+1 and stays at 1 until the next `start_i`.
- R8: `start_i` takes priority over every other event in the same cycle. It clears `timeout_o` and `stall_o`, drops any pending override request, and restarts polling.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts or restarts the bring-up sequence |
| dbg0_i | input | 32 | Debug word 0; bits 5:0 hold the training-state code |
| dbg1_i | input | 32 | Debug word 1; bit 4 is link up, bit 29 is in training |
| rx_valid_i | input | 1 | Receiver-valid flag read from the PHY |
| link_up_o | output | 1 | Registered link-usable decision |
| stall_o | output | 1 | Sticky: a stalled speed change was detected |
| ovr_set_o | output | 1 | One-cycle request to set both receiver override enables |
| ovr_clr_o | output | 1 | One-cycle request to clear both receiver override enables |
| timeout_o | output | 1 | Sticky: the link did not come up within the polling budget |

## Verification
A new `start_i` can arrive in the same cycle as another event. One case is the cycle in which the polling budget expires. The other is a cycle during the override hold, when a clear request is still pending.

The bench drives `start_i` in the exact cycle the budget would run out. It then checks that `timeout_o` stays low and only rises a full budget later. In the second case it restarts during the hold with the link down. It checks that no clear request ever appears and that `stall_o` drops.

// File: rtl/lum_pkg.sv
package lum_pkg;
  localparam int UP_BIT    = 4;
  localparam int TRAIN_BIT = 29;
  localparam int CODE_W    = 6;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_POLL   = 3'd1,
    S_SETTLE = 3'd2,
    S_SET    = 3'd3,
    S_HOLD   = 3'd4,
    S_CLR    = 3'd5
  } seq_state_t;

  function automatic logic link_usable(input logic [31:0] w1);
    return w1[UP_BIT] & ~w1[TRAIN_BIT];
  endfunction

  function automatic logic [CODE_W-1:0] train_code(input logic [31:0] w0);
    return w0[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/lum_decode.sv
module lum_decode
  import lum_pkg::*;
#(
  parameter logic [5:0] RCV_LOCK_CODE = 6'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dbg0_i,
  input  logic [31:0] dbg1_i,
  input  logic        rx_valid_i,
  output logic        link_now,
  output logic        stall_cond,
  output logic        link_q
);
  assign link_now   = link_usable(dbg1_i);
  assign stall_cond = (train_code(dbg0_i) == RCV_LOCK_CODE) && !rx_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_now;
  end
endmodule

// File: rtl/lum_timer.sv
module lum_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);
endmodule

// File: rtl/lum_seq.sv
module lum_seq
  import lum_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       link_now,
  input  logic       stall_cond,
  input  logic       hit,
  output seq_state_t state,
  output logic       cnt_clr,
  output logic       settle_done,
  output logic       stall_hit,
  output logic       budget_out,
  output logic       stall_q,
  output logic       timeout_q
);
  seq_state_t nxt;

  assign settle_done = (state == S_SETTLE) && hit;
  assign stall_hit   = settle_done && stall_cond;
  assign budget_out  = (state == S_POLL) && !link_now && hit;

  always_comb begin
    nxt = state;
    if (start_i) nxt = S_POLL;
    else begin
      case (state)
        S_POLL:   if (link_now) nxt = S_SETTLE;
                  else if (hit) nxt = S_IDLE;
        S_SETTLE: if (hit) nxt = stall_cond ? S_SET : S_IDLE;
        S_SET:    nxt = S_HOLD;
        S_HOLD:   if (hit) nxt = S_CLR;
        S_CLR:    nxt = S_IDLE;
        default:  nxt = S_IDLE;
      endcase
    end
  end

  assign cnt_clr = start_i || (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stall_q   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state <= nxt;
      if (start_i) begin
        stall_q   <= 1'b0;
        timeout_q <= 1'b0;
      end else begin
        if (stall_hit)  stall_q   <= 1'b1;
        if (budget_out) timeout_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_up_monitor.sv
module link_up_monitor
  import lum_pkg::*;
#(
  parameter int         SETTLE_CYC    = 500000,
  parameter int         PULSE_CYC     = 2500,
  parameter int         POLL_BUDGET   = 6000000,
  parameter logic [5:0] RCV_LOCK_CODE = 6'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] dbg0_i,
  input  logic [31:0] dbg1_i,
  input  logic        rx_valid_i,
  output logic        link_up_o,
  output logic        stall_o,
  output logic        ovr_set_o,
  output logic        ovr_clr_o,
  output logic        timeout_o
);
  localparam int MAX_A = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int MAX_V = (MAX_A > POLL_BUDGET) ? MAX_A : POLL_BUDGET;
  localparam int CW    = $clog2(MAX_V + 1);

  logic          link_now, stall_cond, hit, cnt_clr;
  logic          settle_done, stall_hit, budget_out;
  logic [CW-1:0] limit;
  seq_state_t    state;

  function automatic logic [CW-1:0] limit_for(input seq_state_t s);
    case (s)
      S_POLL:   return CW'(POLL_BUDGET - 1);
      S_SETTLE: return CW'(SETTLE_CYC - 1);
      S_HOLD:   return CW'(PULSE_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  assign limit = limit_for(state);

  lum_decode #(.RCV_LOCK_CODE(RCV_LOCK_CODE)) u_dec (
    .clk(clk), .rst_n(rst_n), .dbg0_i(dbg0_i), .dbg1_i(dbg1_i),
    .rx_valid_i(rx_valid_i), .link_now(link_now),
    .stall_cond(stall_cond), .link_q(link_up_o)
  );

  lum_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .limit(limit), .hit(hit)
  );

  lum_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_now(link_now),
    .stall_cond(stall_cond), .hit(hit), .state(state), .cnt_clr(cnt_clr),
    .settle_done(settle_done), .stall_hit(stall_hit),
    .budget_out(budget_out), .stall_q(stall_o), .timeout_q(timeout_o)
  );

  assign ovr_set_o = (state == S_SET);
  assign ovr_clr_o = (state == S_CLR);
endmodule

// File: rtl/lum_checker.sv
module lum_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] dbg1_i,
  input logic        link_up_o,
  input logic        stall_o,
  input logic        ovr_set_o,
  input logic        ovr_clr_o,
  input logic        timeout_o,
  input logic        stall_hit,
  input logic        budget_out
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_link_decode: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> link_up_o == ($past(dbg1_i[4]) && !$past(dbg1_i[29])));

  a_r3_stall_to_set: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hit && !start_i |=> ovr_set_o);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovr_set_o && ovr_clr_o));

  a_r5_set_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_o |=> !ovr_set_o && !ovr_clr_o);

  a_r6_stall_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> ovr_set_o);

  a_r7_timeout_set: assert property (@(posedge clk) disable iff (!rst_n)
    budget_out && !start_i |=> timeout_o);

  a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && !start_i |=> timeout_o);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !timeout_o && !stall_o && !ovr_set_o && !ovr_clr_o);

  always_comb begin
    if (!rst_n) a_r9_reset_quiet: assert (!stall_o && !ovr_set_o && !ovr_clr_o && !timeout_o);
  end
endmodule

bind link_up_monitor lum_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbg1_i(dbg1_i),
  .link_up_o(link_up_o), .stall_o(stall_o), .ovr_set_o(ovr_set_o),
  .ovr_clr_o(ovr_clr_o), .timeout_o(timeout_o),
  .stall_hit(stall_hit), .budget_out(budget_out)
);

// File: tb/test_link_up_monitor.sv
module test_link_up_monitor;
  localparam int S = 4;
  localparam int P = 3;
  localparam int B = 12;
  localparam int SET_CYC = S + 2;
  localparam int CLR_CYC = S + P + 3;
  localparam int RUN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] dbg0_i = '0;
  logic [31:0] dbg1_i = '0;
  logic rx_valid_i = 1'b0;
  logic link_up_o, stall_o, ovr_set_o, ovr_clr_o, timeout_o;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  always #2 clk = ~clk;

  link_up_monitor #(.SETTLE_CYC(S), .PULSE_CYC(P), .POLL_BUDGET(B),
                    .RCV_LOCK_CODE(6'h0D)) i_link_up_monitor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbg0_i(dbg0_i),
    .dbg1_i(dbg1_i), .rx_valid_i(rx_valid_i), .link_up_o(link_up_o),
    .stall_o(stall_o), .ovr_set_o(ovr_set_o), .ovr_clr_o(ovr_clr_o),
    .timeout_o(timeout_o)
  );

  // {dbg1, dbg0, rx_valid, expect_stall, expect_timeout}
  localparam logic [66:0] VEC [7] = '{
    {32'h0000_0010, 32'h0000_000D, 1'b0, 1'b1, 1'b0},
    {32'h0000_0010, 32'h0000_000D, 1'b1, 1'b0, 1'b0},
    {32'h0000_0010, 32'h0000_0011, 1'b0, 1'b0, 1'b0},
    {32'h2000_0010, 32'h0000_000D, 1'b0, 1'b0, 1'b1},
    {32'h0000_0000, 32'h0000_000D, 1'b0, 1'b0, 1'b1},
    {32'hDFFF_FFFF, 32'hABCD_EF4D, 1'b0, 1'b1, 1'b0},
    {32'h0000_0010, 32'h0000_0D00, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_link(input logic [31:0] w);
    return ((w >> 4) & 32'h1) == 32'h1 && ((w >> 29) & 32'h1) == 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs quiet in reset
    repeat (3) @(negedge clk);
    check("R9 reset", {27'd0, link_up_o, stall_o, ovr_set_o, ovr_clr_o, timeout_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      int set_n, clr_n, set_at, clr_at;
      logic to_pre, to_at;
      set_n = 0; clr_n = 0; set_at = -1; clr_at = -1; to_pre = 1'b0; to_at = 1'b0;
      dbg1_i = VEC[v][66:35];
      dbg0_i = VEC[v][34:3];
      rx_valid_i = VEC[v][2];
      start_i = 1'b1;
      for (int k = 1; k <= RUN; k++) begin
        @(negedge clk);
        start_i = 1'b0;
        if (ovr_set_o) begin set_n++; if (set_at < 0) set_at = k; end
        if (ovr_clr_o) begin clr_n++; if (clr_at < 0) clr_at = k; end
        if (k == B) to_pre = timeout_o;
        if (k == B + 1) to_at = timeout_o;
      end
      check("R3 R4 set count", set_n, {31'd0, VEC[v][1]});
      check("R5 R4 clr count", clr_n, {31'd0, VEC[v][1]});
      if (VEC[v][1]) begin
        check("R3 set cycle", set_at, SET_CYC);
        check("R5 clr cycle", clr_at, CLR_CYC);
      end
      check("R6 stall sticky", {31'd0, stall_o}, {31'd0, VEC[v][1]});
      check("R7 timeout final", {31'd0, timeout_o}, {31'd0, VEC[v][0]});
      if (VEC[v][0]) begin
        check("R7 timeout early", {31'd0, to_pre}, 32'd0);
        check("R7 timeout edge", {31'd0, to_at}, 32'd1);
      end
      check("R1 link decode", {31'd0, link_up_o}, {31'd0, exp_link(VEC[v][66:35])});
      check("R2 code masking", {31'd0, stall_o}, {31'd0, VEC[v][1]});
    end

    // R8: start in the very cycle the budget expires
    dbg1_i = '0;
    start_i = 1'b1;
    for (int k = 1; k <= 26; k++) begin
      @(negedge clk);
      start_i = (k == B);
      if (k == B + 1) check("R8 start beats timeout", {31'd0, timeout_o}, 32'd0);
      if (k == 2 * B) check("R8 R7 restarted budget", {31'd0, timeout_o}, 32'd0);
      if (k == 2 * B + 1) check("R8 R7 restarted timeout", {31'd0, timeout_o}, 32'd1);
    end

    // R8 R6: restart during the override hold drops the clear request
    dbg1_i = 32'h0000_0010; dbg0_i = 32'h0000_000D; rx_valid_i = 1'b0;
    start_i = 1'b1;
    begin
      int clr_seen;
      clr_seen = 0;
      for (int k = 1; k <= 9; k++) begin
        @(negedge clk);
        start_i = 1'b0;
        if (k == SET_CYC + 1) check("R6 stall up", {31'd0, stall_o}, 32'd1);
        if (k == SET_CYC + 2) begin
          dbg1_i = '0;
          start_i = 1'b1;
        end
        if (ovr_clr_o) clr_seen++;
      end
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (ovr_clr_o) clr_seen++;
      end
      check("R8 no clear after restart", clr_seen, 0);
      check("R8 R6 stall cleared", {31'd0, stall_o}, 32'd0);
    end

    // R1: link_up follows debug word 1 with one cycle of delay
    dbg1_i = 32'h0000_0010;
    @(negedge clk);
    check("R1 up", {31'd0, link_up_o}, 32'd1);
    dbg1_i = 32'h2000_0010;
    @(negedge clk);
    check("R1 training blocks", {31'd0, link_up_o}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule